// File: doc/BRIEF.md
# Three-Class Exception Entry and Return Controller

This block holds the control state a processor core needs to enter and leave exception handlers in three classes: non-critical (class 0), critical (class 1) and debug (class 2). Each class owns a pair of save registers, one for the return address and one for the saved machine-state word. The pipeline presents per-class pending requests, each with a vector index and a syndrome code, along with the current program counter, the current machine-state word, the software-programmed vector prefix and a per-class return strobe.

When a request is eligible, the block redirects fetch to a vector built from the prefix and a fixed offset. It stores the interrupted context in that class's pair, records the syndrome and produces a supervisor-mode machine state with the relevant enable bits cleared. A return strobe redirects fetch to the saved address of its class and restores the saved machine state. Both actions take effect on the clock edge after the inputs are presented.

Nesting follows from the enable bits. Entering a class clears its own enable bit and those of the classes below it. This leaves higher classes free to interrupt the handler, so a critical request may interrupt a non-critical handler, and a debug request may interrupt either of them.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `redir_vld_o`, `redir_addr_o`, `msr_o`, `esr_o`, `sv_pc_o` and `sv_ms_o` are all zero.
- R2: A request of class c is eligible only if `msr_i[c]` is 1. A debug (class 2) request additionally requires `dbg_en_i` to be 1. Requests that are not eligible have no effect.
- R3: Among eligible requests, debug is taken over critical, and critical is taken over non-critical.
- R4: On the edge after class c is taken, save pair c holds the `pc_i` and `msr_i` of that cycle. Pair c occupies `sv_pc_o[32c+31:32c]` and `sv_ms_o[8c+7:8c]`, and the other two pairs keep their values.
- R5: On the edge after an entry, `redir_vld_o` is 1 and `redir_addr_o` = {`prefix_i[31:16]`, 6'b0, c[1:0], vid[3:0], 4'b0}. Here vid is `req_vid_i[4c+3:4c]`, and the low 16 bits of the prefix have no effect.
- R6: On the edge after an entry, `esr_o` equals `req_syn_i[16c+15:16c]`. In any cycle with no entry, `esr_o` keeps its value.
- R7: On entry, `msr_o` is `msr_i` with bit 3 (supervisor) set and bits 0 through c cleared. All other bits are copied unchanged.
- R8: When no entry is taken, a set `ret_i[r]` gives `redir_vld_o`=1, `redir_addr_o` equal to saved address r and `msr_o` equal to saved state r on the next edge. If several strobes are set, the highest class is used.
- R9: A return strobe in the same cycle as a taken entry is ignored. Only the entry's redirect, state and save occur.
- R10: In a cycle with neither an entry nor a return, the next edge gives `redir_vld_o`=0, and `redir_addr_o` and `msr_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 3 | Pending request per class (bit 0 non-critical, 1 critical, 2 debug) |
| req_vid_i | input | 12 | 4-bit vector index per class |
| req_syn_i | input | 48 | 16-bit syndrome per class |
| pc_i | input | 32 | Return address to save on entry |
| msr_i | input | 8 | Current machine-state word |
| prefix_i | input | 32 | Vector prefix register |
| dbg_en_i | input | 1 | Debug feature enable |
| ret_i | input | 3 | Return strobe per class |
| redir_vld_o | output | 1 | Redirect pulse |
| redir_addr_o | output | 32 | Redirect target |
| msr_o | output | 8 | New machine-state word |
| esr_o | output | 16 | Syndrome register |
| sv_pc_o | output | 96 | Saved return address per class |
| sv_ms_o | output | 24 | Saved machine state per class |

## Verification
Entry and return can both be requested in the same cycle, and so can requests of several classes. The bench sweeps every combination of request bits, enable bits, debug enable and return strobes, so that each coincidence happens many times. Because the save pairs fill with distinct contexts as the sweep runs, a return that leaked through beside an entry, or a lower class that won arbitration, would show a different address, state or save pair. Each outcome is judged against an arithmetic model of entry priority followed by return priority.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NCLS    = 3;
  localparam int SUP_BIT = 3;
  typedef enum logic [1:0] {
    CLS_NC  = 2'd0,
    CLS_CR  = 2'd1,
    CLS_DBG = 2'd2
  } exc_cls_e;
endpackage

// File: rtl/exc_arb.sv
// Picks the entry class among eligible requests and the return class among strobes.
module exc_arb
  import exc_pkg::*;
#(
  parameter int MS_W = 8
) (
  input  logic [NCLS-1:0] req_i,
  input  logic [MS_W-1:0] ms_i,
  input  logic            dbg_en_i,
  input  logic [NCLS-1:0] ret_i,
  output logic            take_o,
  output exc_cls_e        tcls_o,
  output logic            rret_o,
  output exc_cls_e        rcls_o
);
  logic [NCLS-1:0] elig;

  for (genvar c = 0; c < NCLS; c++) begin : g_elig
    if (c == int'(CLS_DBG)) begin : g_dbg
      assign elig[c] = req_i[c] & ms_i[c] & dbg_en_i;
    end else begin : g_plain
      assign elig[c] = req_i[c] & ms_i[c];
    end
  end

  // later (higher) classes override earlier ones
  always_comb begin
    take_o = 1'b0;
    tcls_o = CLS_NC;
    rret_o = 1'b0;
    rcls_o = CLS_NC;
    for (int c = 0; c < NCLS; c++) begin
      if (elig[c]) begin
        take_o = 1'b1;
        tcls_o = exc_cls_e'(c);
      end
      if (ret_i[c]) begin
        rret_o = 1'b1;
        rcls_o = exc_cls_e'(c);
      end
    end
  end
endmodule

// File: rtl/exc_vec.sv
// Handler address: upper prefix bits, zero pad, hardwired offset.
module exc_vec
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int PFX_W = 16,
  parameter int VID_W = 4
) (
  input  logic [AW-1:0]    prefix_i,
  input  exc_cls_e         cls_i,
  input  logic [VID_W-1:0] vid_i,
  output logic [AW-1:0]    addr_o
);
  localparam int OFF_W = 12;
  localparam int GAP_W = AW - PFX_W - OFF_W;
  localparam int OPD_W = OFF_W - 4 - VID_W - 2;

  logic [OFF_W-1:0] off;

  assign off    = {{OPD_W{1'b0}}, cls_i, vid_i, 4'b0000};
  assign addr_o = {prefix_i[AW-1 -: PFX_W], {GAP_W{1'b0}}, off};
endmodule

// File: rtl/exc_bank.sv
// One class's save pair.
module exc_bank #(
  parameter int AW   = 32,
  parameter int MS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [MS_W-1:0] ms_i,
  output logic [AW-1:0]   pc_o,
  output logic [MS_W-1:0] ms_o
);
  logic [AW-1:0]   pc_d;
  logic [MS_W-1:0] ms_d;

  always_comb begin
    pc_d = pc_o;
    ms_d = ms_o;
    if (wr_i) begin
      pc_d = pc_i;
      ms_d = ms_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o <= '0;
      ms_o <= '0;
    end else begin
      pc_o <= pc_d;
      ms_o <= ms_d;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MS_W  = 8,
  parameter int VID_W = 4,
  parameter int SYN_W = 16,
  parameter int PFX_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       req_i,
  input  logic [NCLS*VID_W-1:0] req_vid_i,
  input  logic [NCLS*SYN_W-1:0] req_syn_i,
  input  logic [AW-1:0]         pc_i,
  input  logic [MS_W-1:0]       msr_i,
  input  logic [AW-1:0]         prefix_i,
  input  logic                  dbg_en_i,
  input  logic [NCLS-1:0]       ret_i,
  output logic                  redir_vld_o,
  output logic [AW-1:0]         redir_addr_o,
  output logic [MS_W-1:0]       msr_o,
  output logic [SYN_W-1:0]      esr_o,
  output logic [NCLS*AW-1:0]    sv_pc_o,
  output logic [NCLS*MS_W-1:0]  sv_ms_o
);
  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  logic     take_w, rret_w;
  exc_cls_e tcls_w, rcls_w;

  exc_arb #(.MS_W(MS_W)) u_arb (
    .req_i   (req_i),
    .ms_i    (msr_i),
    .dbg_en_i(dbg_en_i),
    .ret_i   (ret_i),
    .take_o  (take_w),
    .tcls_o  (tcls_w),
    .rret_o  (rret_w),
    .rcls_o  (rcls_w)
  );

  logic [VID_W-1:0] vid_sel;
  logic [SYN_W-1:0] syn_sel;
  logic [AW-1:0]    vec_w;

  assign vid_sel = req_vid_i[int'(tcls_w)*VID_W +: VID_W];
  assign syn_sel = req_syn_i[int'(tcls_w)*SYN_W +: SYN_W];

  exc_vec #(.AW(AW), .PFX_W(PFX_W), .VID_W(VID_W)) u_vec (
    .prefix_i(prefix_i),
    .cls_i   (tcls_w),
    .vid_i   (vid_sel),
    .addr_o  (vec_w)
  );

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    logic wr;
    assign wr = take_w & (tcls_w == exc_cls_e'(c));
    exc_bank #(.AW(AW), .MS_W(MS_W)) u_bank (
      .clk  (clk),
      .rst_n(rst_s),
      .wr_i (wr),
      .pc_i (pc_i),
      .ms_i (msr_i),
      .pc_o (sv_pc_o[c*AW +: AW]),
      .ms_o (sv_ms_o[c*MS_W +: MS_W])
    );
  end

  // entry machine state: supervisor on, own and lower enables off
  logic [MS_W-1:0] ms_entry;
  always_comb begin
    ms_entry          = msr_i;
    ms_entry[SUP_BIT] = 1'b1;
    for (int b = 0; b < NCLS; b++) begin
      if (b <= int'(tcls_w)) ms_entry[b] = 1'b0;
    end
  end

  logic            vld_d;
  logic [AW-1:0]   addr_d;
  logic [MS_W-1:0] ms_d;
  logic [SYN_W-1:0] esr_d;

  always_comb begin
    vld_d  = 1'b0;
    addr_d = redir_addr_o;
    ms_d   = msr_o;
    esr_d  = esr_o;
    if (take_w) begin
      vld_d  = 1'b1;
      addr_d = vec_w;
      ms_d   = ms_entry;
      esr_d  = syn_sel;
    end else if (rret_w) begin
      vld_d  = 1'b1;
      addr_d = sv_pc_o[int'(rcls_w)*AW +: AW];
      ms_d   = sv_ms_o[int'(rcls_w)*MS_W +: MS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      redir_vld_o  <= 1'b0;
      redir_addr_o <= '0;
      msr_o        <= '0;
      esr_o        <= '0;
    end else begin
      redir_vld_o  <= vld_d;
      redir_addr_o <= addr_d;
      msr_o        <= ms_d;
      esr_o        <= esr_d;
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int MS_W  = 8,
  parameter int SYN_W = 16
) (
  input logic                 clk,
  input logic                 rst_s,
  input logic                 take,
  input exc_cls_e             tcls,
  input logic [NCLS-1:0]      req_i,
  input logic [MS_W-1:0]      msr_i,
  input logic                 dbg_en_i,
  input logic [NCLS-1:0]      ret_i,
  input logic [AW-1:0]        pc_i,
  input logic                 redir_vld_o,
  input logic [AW-1:0]        redir_addr_o,
  input logic [MS_W-1:0]      msr_o,
  input logic [SYN_W-1:0]     esr_o,
  input logic [NCLS*AW-1:0]   sv_pc_o,
  input logic [NCLS*MS_W-1:0] sv_ms_o
);
  // R2
  dbg_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (take && tcls == CLS_DBG) |-> (dbg_en_i && msr_i[2]));

  // R3
  dbg_first_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (req_i[2] && msr_i[2] && dbg_en_i) |-> (take && tcls == CLS_DBG));

  // R5
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_s)
    take |=> (redir_vld_o && redir_addr_o[3:0] == 4'h0));

  // R6
  esr_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !take |=> $stable(esr_o));

  // R7
  entry_sup_chk: assert property (@(posedge clk) disable iff (!rst_s)
    take |=> (msr_o[SUP_BIT] && !msr_o[0]));

  // R9
  ret_lose_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (take && ret_i != '0) |=> msr_o[SUP_BIT]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!take && ret_i == '0) |=> (!redir_vld_o && $stable(msr_o) && $stable(redir_addr_o)));

  for (genvar c = 0; c < NCLS; c++) begin : g_pair
    // R4
    pair_save_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (take && tcls == exc_cls_e'(c)) |=> (sv_pc_o[c*AW +: AW] == $past(pc_i)));
    // R4
    pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_s)
      !(take && tcls == exc_cls_e'(c)) |=>
        ($stable(sv_pc_o[c*AW +: AW]) && $stable(sv_ms_o[c*MS_W +: MS_W])));
  end
endmodule

bind exc_ctrl exc_ctrl_chk #(.AW(AW), .MS_W(MS_W), .SYN_W(SYN_W)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .take        (take_w),
  .tcls        (tcls_w),
  .req_i       (req_i),
  .msr_i       (msr_i),
  .dbg_en_i    (dbg_en_i),
  .ret_i       (ret_i),
  .pc_i        (pc_i),
  .redir_vld_o (redir_vld_o),
  .redir_addr_o(redir_addr_o),
  .msr_o       (msr_o),
  .esr_o       (esr_o),
  .sv_pc_o     (sv_pc_o),
  .sv_ms_o     (sv_ms_o)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req_i;
  logic [11:0] req_vid_i;
  logic [47:0] req_syn_i;
  logic [31:0] pc_i;
  logic [7:0]  msr_i;
  logic [31:0] prefix_i;
  logic        dbg_en_i;
  logic [2:0]  ret_i;
  logic        redir_vld_o;
  logic [31:0] redir_addr_o;
  logic [7:0]  msr_o;
  logic [15:0] esr_o;
  logic [95:0] sv_pc_o;
  logic [23:0] sv_ms_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_vid_i(req_vid_i),
    .req_syn_i(req_syn_i), .pc_i(pc_i), .msr_i(msr_i), .prefix_i(prefix_i),
    .dbg_en_i(dbg_en_i), .ret_i(ret_i), .redir_vld_o(redir_vld_o),
    .redir_addr_o(redir_addr_o), .msr_o(msr_o), .esr_o(esr_o),
    .sv_pc_o(sv_pc_o), .sv_ms_o(sv_ms_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] m_pc [3];
  logic [7:0]  m_ms [3];
  logic        m_vld;
  logic [31:0] m_addr;
  logic [7:0]  m_msr;
  logic [15:0] m_esr;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input int v);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s vec=%0d actual=%h expected=%h", tag, v, act, exp);
    end
  endtask

  task automatic check_all(input int v);
    chk("R5/R8/R10 redir_vld", 32'(redir_vld_o), 32'(m_vld), v);
    chk("R5/R8/R10 redir_addr", redir_addr_o, m_addr, v);
    chk("R7/R8 msr", 32'(msr_o), 32'(m_msr), v);
    chk("R6 esr", 32'(esr_o), 32'(m_esr), v);
    for (int c = 0; c < 3; c++) begin
      chk("R4 saved pc", sv_pc_o[c*32 +: 32], m_pc[c], v);
      chk("R4 saved ms", 32'(sv_ms_o[c*8 +: 8]), 32'(m_ms[c]), v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_i = '0; req_vid_i = '0; req_syn_i = '0; pc_i = '0;
    msr_i = '0; prefix_i = '0; dbg_en_i = 1'b0; ret_i = '0;
    for (int c = 0; c < 3; c++) begin m_pc[c] = '0; m_ms[c] = '0; end
    m_vld = 1'b0; m_addr = '0; m_msr = '0; m_esr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    n_vec++;
    check_all(-1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] el;
      int tc, rc;
      req_i    = i[2:0];
      dbg_en_i = i[6];
      ret_i    = i[9:7];
      msr_i    = {4'(i * 5), i[0] ^ i[4], i[5:3]};
      pc_i     = 32'h1000_0000 + 32'(i) * 4;
      prefix_i = {16'(i * 7 + 3), 16'(i * 13)};
      for (int c = 0; c < 3; c++) begin
        req_vid_i[c*4 +: 4]   = 4'(i + c * 5);
        req_syn_i[c*16 +: 16] = 16'(i * 3 + c * 1000);
      end
      // R2 eligibility, R3 priority
      el[0] = req_i[0] & msr_i[0];
      el[1] = req_i[1] & msr_i[1];
      el[2] = req_i[2] & msr_i[2] & dbg_en_i;
      tc = el[2] ? 2 : el[1] ? 1 : el[0] ? 0 : -1;
      rc = ret_i[2] ? 2 : ret_i[1] ? 1 : ret_i[0] ? 0 : -1;
      if (tc >= 0) begin
        // R5 vector, R6 syndrome, R7 state, R9 return ignored
        m_vld  = 1'b1;
        m_addr = {prefix_i[31:16], 6'b0, 2'(tc), req_vid_i[tc*4 +: 4], 4'b0};
        m_esr  = req_syn_i[tc*16 +: 16];
        m_msr  = msr_i | 8'h08;
        for (int b = 0; b <= tc; b++) m_msr[b] = 1'b0;
        m_pc[tc] = pc_i;
        m_ms[tc] = msr_i;
      end else if (rc >= 0) begin
        // R8 return
        m_vld  = 1'b1;
        m_addr = m_pc[rc];
        m_msr  = m_ms[rc];
      end else begin
        // R10 idle
        m_vld = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n_vec++;
      check_all(i);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule